// File: doc/BRIEF.md
# Delta-Sigma Bitstream Decimator

This block is the digital back end of a first-order delta-sigma converter. A comparator built from a differential input receiver produces a raw bit. The block registers that bit on every fast clock and drives the registered bit back out to close the loop through an external RC integrator. The same one-bit stream feeds a boxcar low-pass filter. The filter keeps a running count of the ones among the most recent `TAPS` bits. It updates that count on every clock by adding the arriving bit and removing the bit that drops out of a stored history, so no multiplier is involved.

A rate divider emits a strobe once every `OSR` fast clocks. On each strobe, the window count is scaled to a 16-bit code, corrected for offset and gain, and presented with a one-cycle valid pulse. An all-zero stream yields code 0 (bottom of range). An all-one stream yields 65535 (feedback-pin voltage). The code rises monotonically with the density of ones. `TAPS` must be a power of two. With the defaults (1024 taps, ratio 1024, 100 MHz bit clock) the output rate is close to 98 kHz. Changing the ratio selects other PCM rates.

Top module: `dsm_decimator`

## Requirements
- R1: While `rst_n` is low, `fb_out`, `pcm_valid` and `pcm_data` are all 0.
- R2: `fb_out` equals the value `cmp_in` had at the previous rising clock edge.
- R3: `pcm_valid` stays low until at least `TAPS` clock cycles have passed since reset release, so that the window has filled once.
- R4: `pcm_valid` is high for exactly one cycle at a time, and consecutive pulses are exactly `OSR` cycles apart.
- R5: The window count is the number of ones among the last `TAPS` registered bits. An all-zero stream with zero offset and unity gain gives `pcm_data` = 0.
- R6: The raw code is the window count multiplied by 2^(16 − log2 `TAPS`). When all `TAPS` bits are ones, the raw code saturates to 65535. Codes are monotonic in the count.
- R7: `cal_offset` (unsigned) is subtracted from the raw code, and a negative difference clamps to 0.
- R8: `cal_gain` is unsigned Q1.15, where 0x8000 means unity. The result is (difference × gain) >> 15, saturated to 65535.
- R9: `pcm_data` changes only together with a `pcm_valid` pulse and holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bitstream clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_in | input | 1 | Raw comparator bit from the differential receiver |
| fb_out | output | 1 | Registered modulator bit, driven to the integrator feedback |
| cal_offset | input | 16 | Unsigned offset subtracted from the raw code |
| cal_gain | input | 16 | Unsigned Q1.15 gain, 0x8000 = 1.0 |
| pcm_data | output | 16 | Calibrated output sample |
| pcm_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The comparator input is driven with periodic streams of k ones in every eight bits, for k from 0 to 8. Because the period divides the window length, each pattern gives an exact, phase-independent window count. The all-zero and all-one streams pin down the two ends of the range and the saturation at full scale. Intermediate densities confirm the scaling and its monotonic order. The same streams, combined with several offset and gain settings, separate the clamp below zero, plain attenuation, gain overflow, and the combined subtract-then-multiply order.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
    localparam int PCM_W = 16;
    typedef logic [PCM_W-1:0] pcm_t;
    localparam int GAIN_FRAC = 15;
endpackage

// File: rtl/dsm_bit_sampler.sv
module dsm_bit_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_bit,
    output logic mod_bit
);
    typedef struct packed {
        logic bit_v;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.bit_v = raw_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mod_bit = st_q.bit_v;
endmodule

// File: rtl/dsm_window_sum.sv
module dsm_window_sum #(
    parameter int TAPS = 1024,
    localparam int LOG2T = $clog2(TAPS),
    localparam int SUM_W = LOG2T + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_bit,
    output logic [SUM_W-1:0] win_sum,
    output logic             win_full
);
    typedef struct packed {
        logic [TAPS-1:0]  hist;
        logic [LOG2T-1:0] ptr;
        logic [SUM_W-1:0] sum;
        logic [SUM_W-1:0] fill;
    } state_t;

    state_t st_d, st_q;
    logic   leaving_bit;

    assign leaving_bit = st_q.hist[st_q.ptr];

    always_comb begin
        st_d              = st_q;
        // Oldest bit sits at the write slot: drop it, store the new one.
        st_d.hist[st_q.ptr] = in_bit;
        st_d.ptr          = st_q.ptr + LOG2T'(1);
        st_d.sum          = st_q.sum + SUM_W'(in_bit) - SUM_W'(leaving_bit);
        if (st_q.fill != SUM_W'(TAPS))
            st_d.fill = st_q.fill + SUM_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_sum  = st_q.sum;
    assign win_full = (st_q.fill == SUM_W'(TAPS));
endmodule

// File: rtl/dsm_rate_divider.sv
module dsm_rate_divider #(
    parameter int OSR = 1024,
    localparam int CNT_W = (OSR > 1) ? $clog2(OSR) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic   wrap;

    assign wrap = (st_q.cnt == CNT_W'(OSR - 1));

    always_comb begin
        st_d     = st_q;
        st_d.cnt = wrap ? '0 : st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = wrap && enable;
endmodule

// File: rtl/dsm_pcm_calibrate.sv
module dsm_pcm_calibrate
    import dsm_pkg::*;
#(
    parameter int TAPS = 1024,
    localparam int LOG2T = $clog2(TAPS),
    localparam int SUM_W = LOG2T + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [SUM_W-1:0] win_sum,
    input  pcm_t             offset,
    input  pcm_t             gain,
    output pcm_t             pcm,
    output logic             pcm_vld
);
    typedef struct packed {
        pcm_t data;
        logic vld;
    } state_t;

    state_t       st_d, st_q;
    logic [PCM_W:0] raw_ext;
    pcm_t         raw_code;
    pcm_t         diff;
    logic [2*PCM_W-1:0] prod;
    logic [2*PCM_W-1:0] scaled;
    pcm_t         result;

    // Scaling variant depends on whether the window count is narrower than a sample.
    generate
        if (LOG2T <= PCM_W) begin : g_shift_up
            always_comb raw_ext = (PCM_W+1)'(win_sum) << (PCM_W - LOG2T);
        end else begin : g_shift_down
            always_comb raw_ext = (PCM_W+1)'(win_sum >> (LOG2T - PCM_W));
        end
    endgenerate

    always_comb begin
        // Only a full window sets the top bit: clamp it to the largest code.
        raw_code = raw_ext[PCM_W] ? '1 : raw_ext[PCM_W-1:0];
        diff     = (raw_code < offset) ? '0 : raw_code - offset;
        prod     = diff * gain;
        scaled   = prod >> GAIN_FRAC;
        result   = (|scaled[2*PCM_W-1:PCM_W]) ? '1 : scaled[PCM_W-1:0];
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = strobe;
        if (strobe)
            st_d.data = result;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pcm     = st_q.data;
    assign pcm_vld = st_q.vld;
endmodule

// File: rtl/dsm_decimator.sv
module dsm_decimator
    import dsm_pkg::*;
#(
    parameter int TAPS = 1024,
    parameter int OSR  = 1024,
    localparam int LOG2T = $clog2(TAPS),
    localparam int SUM_W = LOG2T + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmp_in,
    output logic        fb_out,
    input  logic [15:0] cal_offset,
    input  logic [15:0] cal_gain,
    output logic [15:0] pcm_data,
    output logic        pcm_valid
);
    logic             mod_bit;
    logic [SUM_W-1:0] win_sum;
    logic             win_full;
    logic             tick;

    dsm_bit_sampler u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_bit (cmp_in),
        .mod_bit (mod_bit)
    );

    assign fb_out = mod_bit;

    dsm_window_sum #(.TAPS(TAPS)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_bit   (mod_bit),
        .win_sum  (win_sum),
        .win_full (win_full)
    );

    dsm_rate_divider #(.OSR(OSR)) u_divider (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (win_full),
        .tick   (tick)
    );

    dsm_pcm_calibrate #(.TAPS(TAPS)) u_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (tick),
        .win_sum (win_sum),
        .offset  (cal_offset),
        .gain    (cal_gain),
        .pcm     (pcm_data),
        .pcm_vld (pcm_valid)
    );
endmodule

// File: rtl/dsm_decimator_chk.sv
module dsm_decimator_chk #(
    parameter int TAPS = 1024,
    parameter int OSR  = 1024
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmp_in,
    input logic        fb_out,
    input logic [15:0] pcm_data,
    input logic        pcm_valid
);
    int unsigned age_q;
    int unsigned gap_q;
    logic        seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q  <= 0;
            gap_q  <= 0;
            seen_q <= 1'b0;
        end else begin
            if (age_q != 32'hFFFF_FFFF) age_q <= age_q + 1;
            if (pcm_valid) begin
                gap_q  <= 0;
                seen_q <= 1'b1;
            end else begin
                gap_q <= gap_q + 1;
            end
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!pcm_valid && pcm_data == 16'd0 && !fb_out));

    a_r2_feedback_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 0) |-> fb_out == $past(cmp_in));

    a_r3_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |-> age_q >= TAPS);

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |=> !pcm_valid);

    a_r4_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_valid && seen_q) |-> gap_q == OSR - 1);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pcm_valid && age_q != 0) |-> $stable(pcm_data));
endmodule

bind dsm_decimator dsm_decimator_chk #(.TAPS(TAPS), .OSR(OSR)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_in    (cmp_in),
    .fb_out    (fb_out),
    .pcm_data  (pcm_data),
    .pcm_valid (pcm_valid)
);

// File: tb/dsm_decimator_tb_top.sv
module dsm_decimator_tb_top;
    localparam int TAPS  = 64;
    localparam int OSR   = 64;
    localparam int LOG2T = $clog2(TAPS);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_in = 1'b0;
    logic        fb_out;
    logic [15:0] cal_offset = 16'd0;
    logic [15:0] cal_gain = 16'h8000;
    logic [15:0] pcm_data;
    logic        pcm_valid;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    int  ones_k = 0;
    int  phase = 0;
    int  skip_n = 0;
    int  cyc = 0;
    int  first_valid = -1;
    int  last_valid = -1;
    int  gap_checks = 0;
    int  fb_checks = 0;
    logic prev_cmp = 1'b0;
    logic have_prev = 1'b0;
    logic [15:0] held_val = 16'd0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    dsm_decimator #(.TAPS(TAPS), .OSR(OSR)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_in     (cmp_in),
        .fb_out     (fb_out),
        .cal_offset (cal_offset),
        .cal_gain   (cal_gain),
        .pcm_data   (pcm_data),
        .pcm_valid  (pcm_valid)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Model from the requirement text: count -> raw code -> offset -> gain.
    function automatic logic [15:0] model(input int k, input int off, input int gain);
        longint cnt, raw, d, r;
        cnt = (TAPS / 8) * k;
        raw = cnt << (16 - LOG2T);
        if (raw > 65535) raw = 65535;
        d = raw - off;
        if (d < 0) d = 0;
        r = (d * gain) >>> 15;
        if (r > 65535) r = 65535;
        return 16'(r);
    endfunction

    // Stimulus generator and feedback check (R2).
    always @(negedge clk) begin
        if (!rst_n) begin
            check(fb_out == 1'b0 && pcm_valid == 1'b0 && pcm_data == 16'd0,
                  "R1 reset state", int'(pcm_data), 0);
            have_prev = 1'b0;
        end else begin
            cyc++;
            if (have_prev && fb_checks < 32) begin
                fb_checks++;
                check(fb_out == prev_cmp, "R2 feedback bit", int'(fb_out), int'(prev_cmp));
            end
            cmp_in    = (phase < ones_k);
            phase     = (phase + 1) % 8;
            prev_cmp  = cmp_in;
            have_prev = 1'b1;
        end
    end

    // Monitor: timing checks and scoreboard pops.
    always @(negedge clk) begin
        if (rst_n) begin
            if (last_valid >= 0 && cyc - last_valid == 20)
                check(pcm_data == held_val, "R9 hold between strobes", int'(pcm_data), int'(held_val));
            if (pcm_valid) begin
                if (first_valid < 0) begin
                    first_valid = cyc;
                    check(cyc >= TAPS, "R3 first valid after window fill", cyc, TAPS);
                end else if (gap_checks < 6) begin
                    gap_checks++;
                    check(cyc - last_valid == OSR, "R4 strobe spacing", cyc - last_valid, OSR);
                end
                last_valid = cyc;
                held_val   = pcm_data;
                if (skip_n > 0) begin
                    skip_n--;
                end else if (sb_q.size() > 0) begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(pcm_data == it.exp, it.tag, int'(pcm_data), int'(it.exp));
                end
            end
        end
    end

    task automatic run_case(input int k, input int off, input int gain, input string tag);
        item_t it;
        @(negedge clk);
        ones_k     = k;
        cal_offset = 16'(off);
        cal_gain   = 16'(gain);
        skip_n     = 2;
        it.exp     = model(k, off, gain);
        it.tag     = tag;
        sb_q.push_back(it);
        while (sb_q.size() > 0) @(negedge clk);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run_case(0, 0, 16'h8000, "R5 all-zero stream");
        run_case(4, 0, 16'h8000, "R6 half density");
        run_case(3, 0, 16'h8000, "R6 three-eighths density");
        run_case(8, 0, 16'h8000, "R6 all-one saturates");
        run_case(4, 4096, 16'h8000, "R7 offset subtract");
        run_case(1, 10000, 16'h8000, "R7 offset clamp at zero");
        run_case(4, 0, 16'h4000, "R8 half gain");
        run_case(6, 0, 16'hC000, "R8 gain overflow saturates");
        run_case(5, 1000, 16'h6000, "R7 R8 offset then gain");
        done = 1'b1;
        repeat (5) @(negedge clk);
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            report();
        end
    end
endmodule